// File: doc/BRIEF.md
# Stack-Machine Control Sequencer

This block is a small stack-oriented sequencer for tight, hand-written control code. Each clock it executes one word fetched from its own instruction memory. The decoded word steers a set of multiplexers that update the instruction pointer, a data stack and a return stack. The top data value lives in a register. The rest of the data stack and all of the return stack sit in two small memories of their own. Counted loops keep their counters on the data stack, so loops can be nested without dedicated counter registers.

A loader port writes the instruction memory at any time, whether the sequencer is held in reset or running. The sequencer reaches the outside world in three ways. The first is a simple bus whose address always comes from the immediate field of the instruction. The second is a start/done handshake with one external engine. The third is a registered general-purpose output byte.

Top module: `stkseq_core`

## Requirements
- R1: While rst is high, bus_rd, bus_wr and sub_start are low, gpio_out is 0, and the instruction pointer and both stack pointers return to 0. In the first cycle after rst falls, the word at instruction address 0 executes.
- R2: An instruction word is 18 bits: the opcode field is bits [17:8] and the immediate is bits [7:0]. Exactly one opcode bit selects an instruction: bit 8 literal, 9 call, 10 return, 11 jump-if-zero, 12 loop, 13 bus read, 14 bus write, 15 start, 16 wait, 17 set-output. A word with no opcode bit set, or with more than one, changes no stack and no output and advances to the next address. Every instruction except a waiting wait takes one cycle.
- R3: Literal pushes the immediate, zero-extended. Bus read drives bus_rd high for one cycle with bus_addr equal to the immediate, and pushes the bus_rdata value present in that cycle.
- R4: Bus write drives bus_wr high for one cycle, with bus_addr equal to the immediate and bus_wdata equal to the top of the data stack, and pops that value.
- R5: Call saves the address of the next word on the return stack and continues at the immediate. Return continues at the most recently saved address and removes it. Calls nest.
- R6: Jump-if-zero pops the top of the data stack. It continues at the immediate when the popped value is 0, and at the next word otherwise.
- R7: Loop decrements the top of the data stack. When the result is nonzero it keeps the result and continues at the immediate. When the result is zero it pops the counter and continues at the next word. A counter of N runs the body N times.
- R8: Start drives sub_start high for exactly its one cycle and advances. Wait holds the instruction pointer, re-executing itself, until sub_done is high in its cycle, and then advances.
- R9: Set-output loads the immediate into gpio_out, which shows the new value from the next cycle on.
- R10: When ld_we is high, ld_data is written into instruction address ld_addr at the clock edge. The new word is executed whenever that address is fetched at a later edge, including while the sequencer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Loader write enable |
| ld_addr | input | 8 | Loader instruction address |
| ld_data | input | 18 | Loader instruction word |
| bus_addr | output | 8 | Bus address (immediate field) |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data, sampled in the read cycle |
| sub_start | output | 1 | Start pulse to the external engine |
| sub_done | input | 1 | Completion flag from the external engine |
| gpio_out | output | 8 | Registered general-purpose output |

## Verification
The hardest state to reach is a wait that stalls across several cycles while the return stack is in use and the loader rewrites a subroutine that runs later. The stimulus gets there with a program that nests a counted loop inside another and calls a subroutine that makes a further call. It then runs a start/wait pair with sub_done driven at random, so waits last a varying number of cycles. Partway through, the bench rewrites a subroutine through the loader, choosing a cycle in which that address is not being fetched. The new output value must then appear on the next call.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

  localparam int OPW = 10;

  // Opcode bit positions inside the opcode field.
  localparam int B_LIT   = 0;
  localparam int B_CALL  = 1;
  localparam int B_RET   = 2;
  localparam int B_JZ    = 3;
  localparam int B_LOOP  = 4;
  localparam int B_RD    = 5;
  localparam int B_WR    = 6;
  localparam int B_KICK  = 7;
  localparam int B_HOLD  = 8;
  localparam int B_SETIO = 9;

  // Packed so that field order mirrors the opcode bits (lit is bit 0).
  typedef struct packed {
    logic setio;
    logic hold;
    logic kick;
    logic wr;
    logic rd;
    logic loop;
    logic jz;
    logic ret;
    logic call;
    logic lit;
  } op_t;

endpackage

// File: rtl/stkseq_lifo.sv
module stkseq_lifo #(
  parameter int PW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] top,
  output logic [PW-1:0] ptr
);

  localparam int DEPTH = 1 << PW;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr_q;

  // Write then post-increment; pre-decrement then read.
  always_ff @(posedge clk) begin
    if (push) mem[ptr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       ptr_q <= '0;
    else if (push) ptr_q <= ptr_q + PW'(1);
    else if (pop)  ptr_q <= ptr_q - PW'(1);
  end

  assign top = mem[ptr_q - PW'(1)];
  assign ptr = ptr_q;

endmodule

// File: rtl/stkseq_imem.sv
module stkseq_imem #(
  parameter int AW = 8,
  parameter int IW = 18
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] mem [DEPTH];

  // Simple dual-port, registered read, read-before-write on collision.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/stkseq_decode.sv
module stkseq_decode
  import stkseq_pkg::*;
#(
  parameter int IMMW = 8
) (
  input  logic                 run,
  input  logic [OPW+IMMW-1:0]  word,
  output op_t                  op,
  output logic [IMMW-1:0]      imm
);

  logic [OPW-1:0] opb;
  logic           single;

  assign opb    = word[IMMW +: OPW];
  assign imm    = word[IMMW-1:0];
  assign single = (opb != '0) && ((opb & (opb - OPW'(1))) == '0);

  always_comb begin
    op = '0;
    if (run && single) op = op_t'(opb);
  end

endmodule

// File: rtl/stkseq_core.sv
module stkseq_core
  import stkseq_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int PW   = 8,
  parameter int IMMW = 8,
  parameter int GW   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_we,
  input  logic [AW-1:0]        ld_addr,
  input  logic [OPW+IMMW-1:0]  ld_data,
  output logic [IMMW-1:0]      bus_addr,
  output logic                 bus_rd,
  output logic                 bus_wr,
  output logic [DW-1:0]        bus_wdata,
  input  logic [DW-1:0]        bus_rdata,
  output logic                 sub_start,
  input  logic                 sub_done,
  output logic [GW-1:0]        gpio_out
);

  localparam int IW = OPW + IMMW;

  logic [IW-1:0]   instr;
  op_t             op;
  logic [IMMW-1:0] imm;
  logic            run;

  logic [AW-1:0]   ip_q, ip_n, ip_inc, rs_top, imm_ip;
  logic [DW-1:0]   tos_q, tos_n, ds_top;
  logic [PW-1:0]   ds_ptr, rs_ptr;
  logic [GW-1:0]   gpio_q;
  logic            ds_push, ds_pop;
  logic            tos_zero, loop_last, loop_again, take_imm;

  assign run = ~rst;

  // Fetch: the read port is addressed by the next IP, so the registered
  // word always belongs to the current IP.
  stkseq_imem #(.AW(AW), .IW(IW)) u_imem (
    .clk   (clk),
    .we    (ld_we),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (ip_n),
    .rdata (instr)
  );

  stkseq_decode #(.IMMW(IMMW)) u_dec (
    .run  (run),
    .word (instr),
    .op   (op),
    .imm  (imm)
  );

  // Data stack below the top-of-stack register.
  stkseq_lifo #(.PW(PW), .DW(DW)) u_dstk (
    .clk   (clk),
    .rst   (rst),
    .push  (ds_push),
    .pop   (ds_pop),
    .wdata (tos_q),
    .top   (ds_top),
    .ptr   (ds_ptr)
  );

  // Return stack holds continuation addresses.
  stkseq_lifo #(.PW(PW), .DW(AW)) u_rstk (
    .clk   (clk),
    .rst   (rst),
    .push  (op.call),
    .pop   (op.ret),
    .wdata (ip_inc),
    .top   (rs_top),
    .ptr   (rs_ptr)
  );

  assign tos_zero   = (tos_q == '0);
  assign loop_last  = (tos_q == DW'(1));
  assign loop_again = op.loop & ~loop_last;
  assign ds_push    = op.lit | op.rd;
  assign ds_pop     = op.wr | op.jz | (op.loop & loop_last);
  assign take_imm   = op.call | (op.jz & tos_zero) | loop_again;
  assign ip_inc     = ip_q + AW'(1);
  assign imm_ip     = AW'(imm);

  always_comb begin
    if (rst)                        ip_n = '0;
    else if (take_imm)              ip_n = imm_ip;
    else if (op.ret)                ip_n = rs_top;
    else if (op.hold && !sub_done)  ip_n = ip_q;
    else                            ip_n = ip_inc;
  end

  always_comb begin
    tos_n = tos_q;
    if (op.lit)          tos_n = DW'(imm);
    else if (op.rd)      tos_n = bus_rdata;
    else if (loop_again) tos_n = tos_q - DW'(1);
    else if (ds_pop)     tos_n = ds_top;
  end

  always_ff @(posedge clk) begin
    ip_q <= ip_n;
    if (rst) begin
      tos_q  <= '0;
      gpio_q <= '0;
    end else begin
      tos_q <= tos_n;
      if (op.setio) gpio_q <= GW'(imm);
    end
  end

  assign bus_addr  = imm;
  assign bus_rd    = op.rd;
  assign bus_wr    = op.wr;
  assign bus_wdata = tos_q;
  assign sub_start = op.kick;
  assign gpio_out  = gpio_q;

endmodule

// File: rtl/stkseq_chk.sv
module stkseq_chk #(
  parameter int AW   = 8,
  parameter int PW   = 8,
  parameter int IMMW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   ip,
  input logic [PW-1:0]   dsp,
  input logic [PW-1:0]   rsp,
  input logic            op_call,
  input logic            op_ret,
  input logic            op_hold,
  input logic [IMMW-1:0] imm,
  input logic            sub_done,
  input logic            bus_rd,
  input logic            bus_wr,
  input logic            sub_start
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (ip == '0 && dsp == '0 && rsp == '0));

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_rd, bus_wr, sub_start}));

  // R4
  write_pops_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> (dsp == $past(dsp) - PW'(1)));

  // R5
  call_push_chk: assert property (@(posedge clk) disable iff (rst)
    op_call |=> (rsp == $past(rsp) + PW'(1)) && (ip == AW'($past(imm))));

  // R5
  ret_pop_chk: assert property (@(posedge clk) disable iff (rst)
    op_ret |=> (rsp == $past(rsp) - PW'(1)));

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_hold && !sub_done) |=> $stable(ip));

  // R8
  start_adv_chk: assert property (@(posedge clk) disable iff (rst)
    sub_start |=> (ip == $past(ip) + AW'(1)));

endmodule

bind stkseq_core stkseq_chk #(.AW(AW), .PW(PW), .IMMW(IMMW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ip        (ip_q),
  .dsp       (ds_ptr),
  .rsp       (rs_ptr),
  .op_call   (op.call),
  .op_ret    (op.ret),
  .op_hold   (op.hold),
  .imm       (imm),
  .sub_done  (sub_done),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .sub_start (sub_start)
);

// File: tb/stkseq_core_tb.sv
`timescale 1ns/1ps
module stkseq_core_tb;

  logic        clk = 0;
  logic        rst = 1;
  logic        ld_we = 0;
  logic [7:0]  ld_addr = 0;
  logic [17:0] ld_data = 0;
  logic [7:0]  bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata = 0;
  logic        sub_start;
  logic        sub_done = 0;
  logic [7:0]  gpio_out;

  always #2 clk = ~clk;

  stkseq_core u_dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sub_start(sub_start), .sub_done(sub_done),
    .gpio_out(gpio_out)
  );

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  // Behavioural model: whole data stack in one queue, last entry is the top.
  logic [17:0] prog [256];
  int m_ip, m_gpio;
  int dq[$];
  int rq[$];

  int seen_11 = 0, seen_22 = 0, seen_33 = 0, seen_ee = 0, seen_77 = 0;
  int wr30 = 0;

  function automatic logic [17:0] mk(int bitpos, int imm);
    logic [17:0] w;
    w = '0;
    if (bitpos >= 0) w[8 + bitpos] = 1'b1;
    w[7:0] = imm[7:0];
    return w;
  endfunction

  function automatic string tag_of(logic [17:0] w);
    if ($countones(w[17:8]) != 1) return "R2";
    if (w[8] || w[13]) return "R3";
    if (w[14])         return "R4";
    if (w[9] || w[10]) return "R5";
    if (w[11])         return "R6";
    if (w[12])         return "R7";
    if (w[15] || w[16]) return "R8";
    return "R9";
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step(int rdata, bit done);
    logic [17:0] w;
    logic [9:0]  o;
    int imm, t;
    w = prog[m_ip];
    o = w[17:8];
    imm = int'(w[7:0]);
    if ($countones(o) != 1) m_ip = m_ip + 1;
    else if (o[0]) begin dq.push_back(imm); m_ip++; end
    else if (o[1]) begin rq.push_back((m_ip + 1) & 255); m_ip = imm; end
    else if (o[2]) m_ip = rq.pop_back();
    else if (o[3]) begin t = dq.pop_back(); m_ip = (t == 0) ? imm : m_ip + 1; end
    else if (o[4]) begin
      t = (dq[$] - 1) & 255;
      if (t != 0) begin dq[$] = t; m_ip = imm; end
      else begin void'(dq.pop_back()); m_ip++; end
    end
    else if (o[5]) begin dq.push_back(rdata & 255); m_ip++; end
    else if (o[6]) begin void'(dq.pop_back()); m_ip++; end
    else if (o[7]) m_ip++;
    else if (o[8]) begin if (done) m_ip++; end
    else begin m_gpio = imm; m_ip++; end
    m_ip = m_ip & 255;
  endtask

  initial begin
    #400000;
    if (!ended) begin
      fails++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [17:0] w;
    bit exp_rd, exp_wr, exp_st, load_pending;
    int rdv;
    bit dn;
    string tg;

    for (int a = 0; a < 256; a++) prog[a] = '0;
    prog[0]  = mk(9, 8'h5A);
    prog[1]  = mk(0, 3);
    prog[2]  = mk(0, 2);
    prog[3]  = mk(5, 8'h20);
    prog[4]  = mk(6, 8'h30);
    prog[5]  = mk(4, 3);
    prog[6]  = mk(1, 30);
    prog[7]  = mk(4, 2);
    prog[8]  = mk(0, 0);
    prog[9]  = mk(3, 12);
    prog[10] = mk(9, 8'hEE);
    prog[11] = mk(9, 8'hEE);
    prog[12] = mk(0, 7);
    prog[13] = mk(3, 10);
    prog[14] = mk(0, 8'h77) | mk(9, 8'h77);
    prog[15] = mk(7, 0);
    prog[16] = mk(8, 0);
    prog[17] = mk(1, 200);
    prog[18] = mk(-1, 8'h66);
    prog[19] = mk(0, 0);
    prog[20] = mk(3, 0);
    prog[30] = mk(0, 9);
    prog[31] = mk(6, 8'h40);
    prog[32] = mk(1, 40);
    prog[33] = mk(2, 0);
    prog[40] = mk(9, 8'h33);
    prog[41] = mk(2, 0);
    prog[200] = mk(9, 8'h11);
    prog[201] = mk(2, 0);

    // Load the whole program while reset is held (R10).
    repeat (2) @(posedge clk);
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      ld_we = 1; ld_addr = 8'(a); ld_data = prog[a];
    end
    @(negedge clk);
    ld_we = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1", "bus_rd in reset", int'(bus_rd), 0);
    check("R1", "bus_wr in reset", int'(bus_wr), 0);
    check("R1", "sub_start in reset", int'(sub_start), 0);
    check("R1", "gpio in reset", int'(gpio_out), 0);

    m_ip = 0; m_gpio = 0;
    rst = 0;
    load_pending = 0;

    for (int cyc = 0; cyc < 1200; cyc++) begin
      if (cyc > 0) @(negedge clk);
      ld_we = 0;
      rdv = int'($urandom) & 255;
      dn  = (($urandom % 3) == 0);
      bus_rdata = 8'(rdv);
      sub_done  = dn;
      #1;
      w = prog[m_ip];
      tg = tag_of(w);
      if (cyc == 0) tg = "R1";
      exp_rd = ($countones(w[17:8]) == 1) && w[13];
      exp_wr = ($countones(w[17:8]) == 1) && w[14];
      exp_st = ($countones(w[17:8]) == 1) && w[15];
      check(tg, "bus_rd", int'(bus_rd), int'(exp_rd));
      check(tg, "bus_wr", int'(bus_wr), int'(exp_wr));
      check(tg, "sub_start", int'(sub_start), int'(exp_st));
      check(tg, "gpio_out", int'(gpio_out), m_gpio);
      if (exp_rd || exp_wr) check(tg, "bus_addr", int'(bus_addr), int'(w[7:0]));
      if (exp_wr) check(tg, "bus_wdata", int'(bus_wdata), dq[$]);
      if (gpio_out == 8'h11) seen_11++;
      if (gpio_out == 8'h22) seen_22++;
      if (gpio_out == 8'h33) seen_33++;
      if (gpio_out == 8'hEE) seen_ee++;
      if (gpio_out == 8'h77) seen_77++;
      if (bus_wr && bus_addr == 8'h30) wr30++;
      model_step(rdv, dn);
      if (cyc == 500) load_pending = 1;
      // Run-time rewrite, never on the edge that fetches the same address (R10).
      if (load_pending && m_ip != 200) begin
        ld_we = 1; ld_addr = 8'd200; ld_data = mk(9, 8'h22);
        prog[200] = mk(9, 8'h22);
        load_pending = 0;
      end
    end
    @(negedge clk);
    ld_we = 0;

    check("R2", "multi-hot word left gpio untouched (0x77 cycles)", seen_77, 0);
    check("R6", "skipped set-output never seen (0xEE cycles)", seen_ee, 0);
    check("R7", "nested loop writes to 0x30 at least 6", int'(wr30 >= 6), 1);
    check("R5", "nested-call output 0x33 observed", int'(seen_33 > 0), 1);
    check("R10", "loaded subroutine output 0x11 observed", int'(seen_11 > 0), 1);
    check("R10", "rewritten subroutine output 0x22 observed", int'(seen_22 > 0), 1);

    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule